// File: doc/BRIEF.md
# Ping-Pong Buffer DMA Channel

This block is one channel of a DMA engine. It moves 32-bit words between system memory and a peripheral data port. The channel holds two buffer descriptors. Each descriptor is a start address and a length in bytes. The channel works through one buffer, then moves on to the other buffer without help from software. The finished descriptor is then free for software to reload while the other buffer is being moved. This lets a stream run without gaps even when software is slow to respond.

The direction is fixed when the block is built. In transmit mode the channel reads memory and sends the words to the peripheral. In receive mode it takes words from the peripheral and writes them to memory. Each finished buffer raises a pending flag, which can be routed to an interrupt output. If the next buffer is not loaded when it is needed, the channel waits and records the stall in a sticky flag.

Buffer length does not depend on the peripheral's packet size, so one packet may span the boundary between the two buffers.

Top module: `pingpong_dma_chan`

## Requirements
- R1: Configuration writes use the address on `cfgAddr`. Bit 1 of the address selects the descriptor and bit 0 selects start (0) or length (1). Addresses 0 and 1 are the start and length of descriptor 0; addresses 2 and 3 are the start and length of descriptor 1. Bits [1:0] of a written start or length are ignored. Writing a length whose masked value is nonzero marks that descriptor valid and clears its done bit. Writing a masked length of zero leaves the descriptor not valid.
- R2: Address 4 is the control register: bit 0 enables the channel and bit 1 enables the interrupt. While the channel is disabled it makes no memory request. Disabling it sets `activeIdx` back to 0.
- R3: A buffer is moved as length/4 word beats. The first beat uses the start address and each later beat adds 4. Every memory address is word aligned.
- R4: In transmit mode (IS_TX=1) each word read from memory is shown on `perDataOut` with `perValidOut` high. The word is held until `perReadyIn` accepts it, and words leave in address order.
- R5: In receive mode (IS_TX=0) each word accepted from the peripheral is written to memory, with `memWrite` high, at the next address of the active buffer.
- R6: When the last beat of a buffer completes, that descriptor becomes not valid, its done bit is set, `irqPending` is set and `activeIdx` switches to the other descriptor.
- R7: If the other descriptor is valid at completion, the transfer goes on from it with no word lost or repeated, and the stall flag is not set.
- R8: If the other descriptor is not valid at completion, `stallErr` is set and no memory request is made. When that descriptor is later written, the transfer resumes from it.
- R9: `irq` equals `irqPending` while the interrupt enable is set. When the interrupt enable is clear, `irq` stays low but `irqPending` is still set.
- R10: Address 5 is write-one-to-clear: bit 0 clears `irqPending` and bit 1 clears `stallErr`.
- R11: After reset there is no memory request, `irq` is low and `irqPending` is low, `activeIdx` is 0, and both descriptors are not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register address |
| cfgWrData | input | 32 | Configuration write data |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWrite | output | 1 | High for a memory write (receive mode) |
| memAddr | output | ADDR_W | Word-aligned memory address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory accepts or completes the request |
| perValidOut | output | 1 | Transmit word is available |
| perDataOut | output | 32 | Transmit word |
| perReadyIn | input | 1 | Peripheral accepts the transmit word |
| perValidIn | input | 1 | Peripheral offers a receive word |
| perDataIn | input | 32 | Receive word |
| perReadyOut | output | 1 | Channel accepts the receive word |
| activeIdx | output | 1 | Index of the descriptor in use |
| descValid | output | 2 | Valid bit of each descriptor |
| doneFlags | output | 2 | Completion bit of each descriptor |
| irqPending | output | 1 | A buffer has finished and the flag is not yet cleared |
| stallErr | output | 1 | Sticky flag: the next buffer was not ready |
| irq | output | 1 | Interrupt request (pending and enabled) |

## Verification
The hardest case to reach is a stall followed by recovery. It needs a buffer to finish while the other descriptor is empty, then a descriptor write that arrives while the channel is waiting. The bench runs a single short buffer to completion and confirms that the request line stays quiet for many cycles. It then loads the second descriptor and checks that the words resume at the new address. A second run loads both buffers with a peripheral ready signal that toggles. This puts a rollover under backpressure, and the stall flag is sampled at the moment the first buffer is marked done.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_PER} chanState_t;

  typedef struct packed {
    logic sel;      // descriptor in use
    logic step;     // advance address, consume one word of length
    logic capture;  // load the beat data register
    logic finish;   // last beat of the active buffer done
  } dpStrobe_t;

  localparam logic [2:0] REG_CTRL = 3'd4;
  localparam logic [2:0] REG_CLR  = 3'd5;
endpackage

// File: rtl/pp_dma_dpath.sv
module pp_dma_dpath
  import pp_dma_pkg::*;
#(
  parameter bit IS_TX  = 1'b1,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgAddr,
  input  logic [31:0]       cfgWrData,
  input  dpStrobe_t         strobe,
  input  logic [31:0]       memRdata,
  input  logic [31:0]       perDataIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       beatData,
  output logic [1:0]        descValid,
  output logic              actLast,
  output logic              actEmpty
);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(4);
  localparam logic [LEN_W-1:0]  LEN_STEP  = LEN_W'(4);

  logic [ADDR_W-1:0] curAddr [2];
  logic [LEN_W-1:0]  remain  [2];
  logic [LEN_W-1:0]  lenMasked;

  assign lenMasked = {cfgWrData[LEN_W-1:2], 2'b00};

  for (genvar i = 0; i < 2; i++) begin : g_desc
    logic wrStart, wrLen, mine;
    assign wrStart = cfgWrEn && (cfgAddr[2] == 1'b0) && (cfgAddr[1] == i[0]) && !cfgAddr[0];
    assign wrLen   = cfgWrEn && (cfgAddr[2] == 1'b0) && (cfgAddr[1] == i[0]) &&  cfgAddr[0];
    assign mine    = (strobe.sel == i[0]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        curAddr[i]   <= '0;
        remain[i]    <= '0;
        descValid[i] <= 1'b0;
      end else begin
        if (wrStart)                curAddr[i] <= {cfgWrData[ADDR_W-1:2], 2'b00};
        else if (strobe.step && mine) curAddr[i] <= curAddr[i] + ADDR_STEP;

        if (wrLen)                  remain[i] <= lenMasked;
        else if (strobe.step && mine) remain[i] <= remain[i] - LEN_STEP;

        if (wrLen)                    descValid[i] <= (lenMasked != '0);
        else if (strobe.finish && mine) descValid[i] <= 1'b0;
      end
    end
  end

  assign memAddr  = curAddr[strobe.sel];
  assign actLast  = (remain[strobe.sel] == LEN_STEP);
  assign actEmpty = (remain[strobe.sel] == '0);

  always_ff @(posedge clk) begin
    if (!rstN)               beatData <= '0;
    else if (strobe.capture) beatData <= IS_TX ? memRdata : perDataIn;
  end
endmodule

// File: rtl/pp_dma_ctrl.sv
module pp_dma_ctrl
  import pp_dma_pkg::*;
#(
  parameter bit IS_TX = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [2:0] cfgAddr,
  input  logic [1:0] cfgBits,
  input  logic [1:0] descValid,
  input  logic       actLast,
  input  logic       actEmpty,
  input  logic       memAck,
  input  logic       perValidIn,
  input  logic       perReadyIn,
  output dpStrobe_t  strobe,
  output logic       memReq,
  output logic       memWrite,
  output logic       perValidOut,
  output logic       perReadyOut,
  output logic       chanEn,
  output logic       activeIdx,
  output logic [1:0] doneFlags,
  output logic       irqPending,
  output logic       stallErr,
  output logic       irq
);
  chanState_t state, stateNext;
  logic irqEn, enNext, wrCtrl, wrClr, perHs, beatEnd;

  assign wrCtrl = cfgWrEn && (cfgAddr == REG_CTRL);
  assign wrClr  = cfgWrEn && (cfgAddr == REG_CLR);
  assign enNext = wrCtrl ? cfgBits[0] : chanEn;

  assign memReq      = (state == ST_MEM);
  assign memWrite    = !IS_TX;
  assign perValidOut = IS_TX && (state == ST_PER);
  assign perReadyOut = !IS_TX && (state == ST_PER);
  assign perHs       = (state == ST_PER) && (IS_TX ? perReadyIn : perValidIn);
  assign beatEnd     = IS_TX ? perHs : (memReq && memAck);

  always_comb begin
    strobe.sel     = activeIdx;
    strobe.step    = memReq && memAck;
    strobe.capture = IS_TX ? (memReq && memAck) : perHs;
    strobe.finish  = beatEnd && (IS_TX ? actEmpty : actLast);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (chanEn && descValid[activeIdx]) stateNext = IS_TX ? ST_MEM : ST_PER;
      ST_MEM:  if (memAck) stateNext = IS_TX ? ST_PER : ST_IDLE;
      ST_PER:  if (perHs)  stateNext = IS_TX ? ST_IDLE : ST_MEM;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      chanEn     <= 1'b0;
      irqEn      <= 1'b0;
      activeIdx  <= 1'b0;
      doneFlags  <= '0;
      irqPending <= 1'b0;
      stallErr   <= 1'b0;
    end else begin
      chanEn <= enNext;
      if (wrCtrl) irqEn <= cfgBits[1];
      state <= enNext ? stateNext : ST_IDLE;

      if (!enNext)            activeIdx <= 1'b0;
      else if (strobe.finish) activeIdx <= ~activeIdx;

      for (int i = 0; i < 2; i++) begin
        if (strobe.finish && (activeIdx == i[0]))
          doneFlags[i] <= 1'b1;
        else if (cfgWrEn && !cfgAddr[2] && (cfgAddr[1] == i[0]) && cfgAddr[0])
          doneFlags[i] <= 1'b0;
      end

      if (strobe.finish)              irqPending <= 1'b1;
      else if (wrClr && cfgBits[0])   irqPending <= 1'b0;

      if (strobe.finish && !descValid[~activeIdx]) stallErr <= 1'b1;
      else if (wrClr && cfgBits[1])                stallErr <= 1'b0;
    end
  end

  assign irq = irqPending && irqEn;
endmodule

// File: rtl/pingpong_dma_chan.sv
module pingpong_dma_chan
  import pp_dma_pkg::*;
#(
  parameter bit IS_TX  = 1'b1,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgAddr,
  input  logic [31:0]       cfgWrData,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  output logic              perValidOut,
  output logic [31:0]       perDataOut,
  input  logic              perReadyIn,
  input  logic              perValidIn,
  input  logic [31:0]       perDataIn,
  output logic              perReadyOut,
  output logic              activeIdx,
  output logic [1:0]        descValid,
  output logic [1:0]        doneFlags,
  output logic              irqPending,
  output logic              stallErr,
  output logic              irq
);
  dpStrobe_t   strobe;
  logic        chanEn, actLast, actEmpty;
  logic [31:0] beatData;

  pp_dma_ctrl #(.IS_TX(IS_TX)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgBits(cfgWrData[1:0]), .descValid(descValid), .actLast(actLast),
    .actEmpty(actEmpty), .memAck(memAck), .perValidIn(perValidIn),
    .perReadyIn(perReadyIn), .strobe(strobe), .memReq(memReq),
    .memWrite(memWrite), .perValidOut(perValidOut), .perReadyOut(perReadyOut),
    .chanEn(chanEn), .activeIdx(activeIdx), .doneFlags(doneFlags),
    .irqPending(irqPending), .stallErr(stallErr), .irq(irq)
  );

  pp_dma_dpath #(.IS_TX(IS_TX), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) dpath_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .strobe(strobe), .memRdata(memRdata),
    .perDataIn(perDataIn), .memAddr(memAddr), .beatData(beatData),
    .descValid(descValid), .actLast(actLast), .actEmpty(actEmpty)
  );

  assign memWdata   = beatData;
  assign perDataOut = beatData;
endmodule

// File: rtl/pp_dma_chk.sv
module pp_dma_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              chanEn,
  input logic              cfgWrEn,
  input logic              memReq,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              activeIdx,
  input logic              irqPending,
  input logic [1:0]        descValid,
  input logic [1:0]        doneFlags
);
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |-> !memReq); // R2
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00)); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && $past(memReq) && !$past(memAck)) |-> $stable(memAddr)); // R3
  AST_ROLLOVER_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irqPending) && chanEn) |-> (activeIdx != $past(activeIdx))); // R6
  AST_DONE_INVALID0: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(doneFlags[0]) && !$past(cfgWrEn)) |-> !descValid[0]); // R6
  AST_DONE_INVALID1: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(doneFlags[1]) && !$past(cfgWrEn)) |-> !descValid[1]); // R6
endmodule

bind pingpong_dma_chan pp_dma_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .chanEn(chanEn), .cfgWrEn(cfgWrEn), .memReq(memReq),
  .memAck(memAck), .memAddr(memAddr), .activeIdx(activeIdx),
  .irqPending(irqPending), .descValid(descValid), .doneFlags(doneFlags)
);

// File: tb/pingpong_dma_chan_tb_top.sv
module pingpong_dma_chan_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic        txCfgWe = 1'b0, rxCfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;

  logic        txMemReq, txMemWrite, txPerValid, txPerReady = 1'b1;
  logic [15:0] txMemAddr;
  logic [31:0] txMemWdata, txMemRdata, txPerData;
  logic        txRdy, txAct, txPend, txStall, txIrq;
  logic [1:0]  txValid, txDone;

  logic        rxMemReq, rxMemWrite, rxPerValid = 1'b0, rxPerReady;
  logic [15:0] rxMemAddr;
  logic [31:0] rxMemWdata, rxPerData, rxUnusedOut;
  logic        rxUnusedValid, rxAct, rxPend, rxStall, rxIrq;
  logic [1:0]  rxValid, rxDone;
  int          rxSent = 0;
  logic        rxHsPend = 1'b0;

  assign txMemRdata = {16'h5A5A, txMemAddr};
  assign rxPerData  = 32'hC000_0000 + rxSent;

  pingpong_dma_chan #(.IS_TX(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(txCfgWe), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .memReq(txMemReq), .memWrite(txMemWrite), .memAddr(txMemAddr), .memWdata(txMemWdata),
    .memRdata(txMemRdata), .memAck(txMemReq), .perValidOut(txPerValid),
    .perDataOut(txPerData), .perReadyIn(txPerReady), .perValidIn(1'b0),
    .perDataIn(32'h0), .perReadyOut(txRdy), .activeIdx(txAct), .descValid(txValid),
    .doneFlags(txDone), .irqPending(txPend), .stallErr(txStall), .irq(txIrq)
  );

  pingpong_dma_chan #(.IS_TX(1'b0)) rxDut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(rxCfgWe), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .memReq(rxMemReq), .memWrite(rxMemWrite), .memAddr(rxMemAddr), .memWdata(rxMemWdata),
    .memRdata(32'h0), .memAck(rxMemReq), .perValidOut(rxUnusedValid),
    .perDataOut(rxUnusedOut), .perReadyIn(1'b0), .perValidIn(rxPerValid),
    .perDataIn(rxPerData), .perReadyOut(rxPerReady), .activeIdx(rxAct),
    .descValid(rxValid), .doneFlags(rxDone), .irqPending(rxPend),
    .stallErr(rxStall), .irq(rxIrq)
  );

  // monitors, sampled mid-cycle
  logic [31:0] txLog [64];
  int          txCnt = 0, txReqCycles = 0;
  logic [15:0] rxAddrLog [64];
  logic [31:0] rxDataLog [64];
  int          rxCnt = 0;
  logic        bpMode = 1'b0;

  always @(negedge clk) begin
    if (txMemReq) txReqCycles++;
    if (txPerValid && txPerReady && txCnt < 64) begin txLog[txCnt] = txPerData; txCnt++; end
    if (rxMemReq && rxMemWrite && rxCnt < 64) begin
      rxAddrLog[rxCnt] = rxMemAddr; rxDataLog[rxCnt] = rxMemWdata; rxCnt++;
    end
    if (rxHsPend) rxSent++;
    rxHsPend = rxPerValid && rxPerReady;
    txPerReady = bpMode ? ~txPerReady : 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input bit toRx, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgAddr = a; cfgWrData = d;
    if (toRx) rxCfgWe = 1'b1; else txCfgWe = 1'b1;
    @(negedge clk);
    txCfgWe = 1'b0; rxCfgWe = 1'b0;
  endtask

  task automatic waitTx(input int target);
    for (int k = 0; k < 400 && txCnt < target; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    check("R11 memReq", {31'b0, txMemReq}, 32'd0);
    check("R11 irq", {30'b0, txIrq, txPend}, 32'd0);
    check("R11 active", {31'b0, txAct}, 32'd0);
    check("R11 valid", {30'b0, txValid}, 32'd0);
  endtask

  task automatic testSingleAndStall();
    int base, reqs;
    cfgWrite(0, 3'd0, 32'h0000_0102);   // start, low bits dropped
    cfgWrite(0, 3'd1, 32'd12);
    check("R1 valid set", {30'b0, txValid}, 32'd1);
    cfgWrite(0, 3'd4, 32'd3);
    waitTx(3);
    check("R3 beats", txCnt, 3);
    check("R4 word0", txLog[0], 32'h5A5A_0100);
    check("R4 word1", txLog[1], 32'h5A5A_0104);
    check("R4 word2", txLog[2], 32'h5A5A_0108);
    check("R6 active", {31'b0, txAct}, 32'd1);
    check("R6 valid/done", {28'b0, txValid, txDone}, 32'b0001);
    check("R6 pending", {31'b0, txPend}, 32'd1);
    check("R9 irq", {31'b0, txIrq}, 32'd1);
    check("R8 stall", {31'b0, txStall}, 32'd1);
    reqs = txReqCycles;
    repeat (20) @(negedge clk);
    check("R8 no req while stalled", txReqCycles, reqs);
    cfgWrite(0, 3'd5, 32'd3);
    check("R10 clear", {30'b0, txPend, txStall}, 32'd0);
    base = txCnt;
    cfgWrite(0, 3'd2, 32'h0000_0400);
    cfgWrite(0, 3'd3, 32'd8);
    waitTx(base + 2);
    check("R8 resume cnt", txCnt, base + 2);
    check("R8 resume w0", txLog[base], 32'h5A5A_0400);
    check("R8 resume w1", txLog[base+1], 32'h5A5A_0404);
    check("R6 back to 0", {31'b0, txAct}, 32'd0);
  endtask

  task automatic testDisable();
    int reqs;
    cfgWrite(0, 3'd5, 32'd3);
    cfgWrite(0, 3'd0, 32'h0000_0500);
    cfgWrite(0, 3'd1, 32'd4);
    waitTx(txCnt + 1);
    check("R6 active 1", {31'b0, txAct}, 32'd1);
    cfgWrite(0, 3'd4, 32'd0);
    check("R2 active reset", {31'b0, txAct}, 32'd0);
    cfgWrite(0, 3'd0, 32'h0000_0600);
    cfgWrite(0, 3'd1, 32'd4);
    reqs = txReqCycles;
    repeat (15) @(negedge clk);
    check("R2 no req when off", txReqCycles, reqs);
    cfgWrite(0, 3'd3, 32'd3);           // masks to zero
    check("R1 zero len invalid", {30'b0, txValid}, 32'd1);
    cfgWrite(0, 3'd1, 32'd0);
    check("R1 zero len clears", {30'b0, txValid}, 32'd0);
  endtask

  task automatic testPingPongMasked();
    int base;
    cfgWrite(0, 3'd5, 32'd3);
    cfgWrite(0, 3'd0, 32'h0000_0200);
    cfgWrite(0, 3'd1, 32'h0000_000B);   // 8 bytes after masking
    cfgWrite(0, 3'd2, 32'h0000_0300);
    cfgWrite(0, 3'd3, 32'd8);
    check("R1 done cleared", {30'b0, txDone}, 32'd0);
    base = txCnt;
    bpMode = 1'b1;
    cfgWrite(0, 3'd4, 32'd1);           // enable, interrupt masked
    for (int k = 0; k < 400 && !txDone[0]; k++) @(negedge clk);
    check("R7 no stall at rollover", {31'b0, txStall}, 32'd0);
    waitTx(base + 4);
    bpMode = 1'b0;
    check("R7 cnt", txCnt, base + 4);
    check("R7 w0", txLog[base],   32'h5A5A_0200);
    check("R7 w1", txLog[base+1], 32'h5A5A_0204);
    check("R7 w2", txLog[base+2], 32'h5A5A_0300);
    check("R7 w3", txLog[base+3], 32'h5A5A_0304);
    check("R9 masked", {30'b0, txPend, txIrq}, 32'b10);
    cfgWrite(0, 3'd4, 32'd0);
  endtask

  task automatic testRx();
    cfgWrite(1, 3'd0, 32'h0000_0800);
    cfgWrite(1, 3'd1, 32'd8);
    cfgWrite(1, 3'd2, 32'h0000_0900);
    cfgWrite(1, 3'd3, 32'd4);
    cfgWrite(1, 3'd4, 32'd3);
    @(negedge clk); rxPerValid = 1'b1;
    for (int k = 0; k < 400 && rxCnt < 3; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    rxPerValid = 1'b0;
    check("R5 cnt", rxCnt, 3);
    check("R5 a0", {16'b0, rxAddrLog[0]}, 32'h0800);
    check("R5 a1", {16'b0, rxAddrLog[1]}, 32'h0804);
    check("R5 a2", {16'b0, rxAddrLog[2]}, 32'h0900);
    check("R5 d0", rxDataLog[0], 32'hC000_0000);
    check("R5 d2", rxDataLog[2], 32'hC000_0002);
    check("R6 rx done", {28'b0, rxValid, rxDone}, 32'b0011);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingleAndStall();
    testDisable();
    testPingPongMasked();
    testRx();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule